// File: doc/BRIEF.md
# Bit-Masked General-Purpose I/O Port

This block is one eight-pin general-purpose I/O port sitting behind a simple single-cycle register bus. Software owns three per-pin configuration registers: pin direction, digital enable and peripheral hand-over. It reaches the pin data through a 256-word window. The word address inside that window is itself a per-bit mask, so a single store can change some pins without disturbing the others, and a single load can sample a chosen subset of them.

Each pin is either under software control or lent to an on-chip peripheral. In software mode the stored data bit drives the pad and the direction bit drives the pad enable. In peripheral mode the peripheral supplies both. The digital enable must be set for either use, and clearing it tristates the pad and blanks the pin's input. Pad inputs go through a two-stage synchronizer before anything inside the block sees them. The synchronized, enable-gated levels are also passed on to the peripheral.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, peripheral-select and digital-enable registers are all zero, `pad_oe_o` and `pad_out_o` are zero, and `bus_rdata_o` is zero.
- R2: A write in the data window (byte address bits [11:10] equal to 0) updates only those data bits whose matching address bit in [9:2] is 1. Address bit k+2 guards data bit k. All other data bits keep their value.
- R3: A read in the data window returns, for each bit whose mask address bit is 1, the stored data bit if the pin's direction bit is 1, or the synchronized pin level if it is 0. Bits whose mask address bit is 0 read as zero.
- R4: Read data appears on `bus_rdata_o` in the cycle after the read request. In every cycle that does not follow a read request, `bus_rdata_o` is zero.
- R5: In software mode (peripheral-select bit 0) with digital enable 1, `pad_out_o` carries the stored data bit and `pad_oe_o` carries the direction bit (1 = output).
- R6: In peripheral mode (peripheral-select bit 1) with digital enable 1, `pad_out_o` and `pad_oe_o` follow `periph_out_i` and `periph_oe_i`.
- R7: A pin whose digital-enable bit is 0 has `pad_out_o` and `pad_oe_o` at 0. Its level is seen as 0 on `periph_in_o` and on data-window reads.
- R8: A change on `pad_in_i` reaches `periph_in_o` after exactly two rising clock edges.
- R9: The direction register sits at byte offset 0x400, peripheral-select at 0x420 and digital-enable at 0x51C. Bits [7:0] of each are read and written, and higher read bits are zero. Any other address outside the data window reads as zero, and a write to it changes no register.
- R10: A register write changes that register, and the port outputs that depend on it, on the first rising edge after the request.
- R11: A data write to a pin in peripheral mode is stored but does not reach `pad_out_o` until the pin is returned to software mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data (bits [7:0] used) |
| bus_rdata_o | output | 32 | Registered read data |
| pad_in_i | input | 8 | Asynchronous pad levels |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad output enable |
| periph_out_i | input | 8 | Peripheral output value |
| periph_oe_i | input | 8 | Peripheral output enable |
| periph_in_o | output | 8 | Synchronized, enable-gated pad levels |

## Verification
The overlap that matters is between a masked data store and peripheral ownership of the same pins. The store commits to the data register while the pad keeps showing the peripheral's value. The bench arranges this by lending the upper nibble to the peripheral and then storing a full byte through the all-ones mask. It checks that the pad shows the peripheral in the upper half and the new data in the lower half. It then hands the pins back and checks that the stored upper nibble appears on the pad with no further write. A second overlap is a load that mixes output and input pins in one word, where each bit must come from its own source.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned GP_PINS   = 8;
  localparam int unsigned GP_ADDR_W = 12;
  localparam int unsigned GP_DATA_W = 32;

  // byte offsets of the configuration registers
  localparam logic [GP_ADDR_W-1:0] OFS_DIR = 12'h400;
  localparam logic [GP_ADDR_W-1:0] OFS_ALT = 12'h420;
  localparam logic [GP_ADDR_W-1:0] OFS_DEN = 12'h51C;

  // first address bit used as a data mask
  localparam int unsigned MASK_LSB = 2;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DATA = 3'd1,
    SEL_DIR  = 3'd2,
    SEL_ALT  = 3'd3,
    SEL_DEN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS = GP_PINS,
  parameter int unsigned ADDR_W = GP_ADDR_W,
  parameter int unsigned DATA_W = GP_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] pin_lvl_i,
  output logic [N_PINS-1:0] data_o,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] alt_o,
  output logic [N_PINS-1:0] den_o
);
  localparam int unsigned MASK_MSB = MASK_LSB + N_PINS - 1;
  localparam int unsigned WORD_LSB = MASK_LSB;

  logic [N_PINS-1:0] data_q, dir_q, alt_q, den_q;
  logic [DATA_W-1:0] rdata_q;
  logic [N_PINS-1:0] mask;
  logic [N_PINS-1:0] wbits;
  logic [N_PINS-1:0] data_view;
  logic [N_PINS-1:0] rd_bits;
  logic              in_window;
  logic              wr_req, rd_req;
  reg_sel_e          sel;

  assign mask      = bus_addr_i[MASK_MSB:MASK_LSB];
  assign wbits     = bus_wdata_i[N_PINS-1:0];
  assign in_window = (bus_addr_i[ADDR_W-1:MASK_MSB+1] == '0);
  assign wr_req    = bus_valid_i &  bus_write_i;
  assign rd_req    = bus_valid_i & ~bus_write_i;

  always_comb begin
    sel = SEL_NONE;
    if (in_window)
      sel = SEL_DATA;
    else if (bus_addr_i[ADDR_W-1:WORD_LSB] == OFS_DIR[ADDR_W-1:WORD_LSB])
      sel = SEL_DIR;
    else if (bus_addr_i[ADDR_W-1:WORD_LSB] == OFS_ALT[ADDR_W-1:WORD_LSB])
      sel = SEL_ALT;
    else if (bus_addr_i[ADDR_W-1:WORD_LSB] == OFS_DEN[ADDR_W-1:WORD_LSB])
      sel = SEL_DEN;
  end

  // output pins report the stored bit, input pins the sampled level
  assign data_view = (dir_q & data_q) | (~dir_q & pin_lvl_i);

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_bits = data_view & mask;
      SEL_DIR:  rd_bits = dir_q;
      SEL_ALT:  rd_bits = alt_q;
      SEL_DEN:  rd_bits = den_q;
      default:  rd_bits = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      alt_q  <= '0;
      den_q  <= '0;
    end else if (wr_req) begin
      unique case (sel)
        SEL_DATA: data_q <= (data_q & ~mask) | (wbits & mask);
        SEL_DIR:  dir_q  <= wbits;
        SEL_ALT:  alt_q  <= wbits;
        SEL_DEN:  den_q  <= wbits;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= DATA_W'(rd_bits);
    else             rdata_q <= '0;
  end

  assign bus_rdata_o = rdata_q;
  assign data_o      = data_q;
  assign dir_o       = dir_q;
  assign alt_o       = alt_q;
  assign den_o       = den_q;

  a_r2_unmasked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && in_window) |=> (((data_q ^ $past(data_q)) & ~$past(mask)) == '0));

  a_r2_masked_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && in_window) |=> ((data_q & $past(mask)) == ($past(wbits) & $past(mask))));

  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> (bus_rdata_o == '0));

  a_r10_dir_next_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && bus_addr_i[ADDR_W-1:WORD_LSB] == OFS_DIR[ADDR_W-1:WORD_LSB])
      |=> (dir_q == $past(wbits)));

  a_r9_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && sel == SEL_NONE)
      |=> ($stable(data_q) && $stable(dir_q) && $stable(alt_q) && $stable(den_q)));
endmodule

// File: rtl/gpio_port_pin_mux.sv
module gpio_port_pin_mux #(
  parameter int unsigned N_PINS = 8
) (
  input  logic [N_PINS-1:0] data_i,
  input  logic [N_PINS-1:0] dir_i,
  input  logic [N_PINS-1:0] alt_i,
  input  logic [N_PINS-1:0] den_i,
  input  logic [N_PINS-1:0] sync_i,
  input  logic [N_PINS-1:0] periph_out_i,
  input  logic [N_PINS-1:0] periph_oe_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] lvl_o
);
  generate
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      logic src_out, src_oe;
      assign src_out      = alt_i[p] ? periph_out_i[p] : data_i[p];
      assign src_oe       = alt_i[p] ? periph_oe_i[p]  : dir_i[p];
      assign pad_out_o[p] = den_i[p] & src_out;
      assign pad_oe_o[p]  = den_i[p] & src_oe;
      assign lvl_o[p]     = den_i[p] & sync_i[p];
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS = GP_PINS,
  parameter int unsigned ADDR_W = GP_ADDR_W,
  parameter int unsigned DATA_W = GP_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] pad_in_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  input  logic [N_PINS-1:0] periph_out_i,
  input  logic [N_PINS-1:0] periph_oe_i,
  output logic [N_PINS-1:0] periph_in_o
);
  logic [N_PINS-1:0] sync_lvl, gated_lvl;
  logic [N_PINS-1:0] data_r, dir_r, alt_r, den_r;

  gpio_port_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (sync_lvl)
  );

  gpio_port_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pin_lvl_i   (gated_lvl),
    .data_o      (data_r),
    .dir_o       (dir_r),
    .alt_o       (alt_r),
    .den_o       (den_r)
  );

  gpio_port_pin_mux #(.N_PINS(N_PINS)) u_mux (
    .data_i       (data_r),
    .dir_i        (dir_r),
    .alt_i        (alt_r),
    .den_i        (den_r),
    .sync_i       (sync_lvl),
    .periph_out_i (periph_out_i),
    .periph_oe_i  (periph_oe_i),
    .pad_out_o    (pad_out_o),
    .pad_oe_o     (pad_oe_o),
    .lvl_o        (gated_lvl)
  );

  assign periph_in_o = gated_lvl;

  a_r7_oe_needs_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o | pad_out_o) & ~den_r) == '0);

  a_r6_alt_follows_periph: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pad_out_o ^ periph_out_i) | (pad_oe_o ^ periph_oe_i)) & alt_r & den_r) == '0);

  a_r11_sw_drives_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ data_r) & ~alt_r & den_r) == '0);
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe;
  logic [7:0]  periph_out = '0;
  logic [7:0]  periph_oe = '0;
  logic [7:0]  periph_in;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_port u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .bus_valid_i  (bus_valid),
    .bus_write_i  (bus_write),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .pad_in_i     (pad_in),
    .pad_out_o    (pad_out),
    .pad_oe_o     (pad_oe),
    .periph_out_i (periph_out),
    .periph_oe_i  (periph_oe),
    .periph_in_o  (periph_in)
  );

  typedef struct packed {
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic [11:0] rd_addr;
    logic [7:0]  rd_exp;
    logic [7:0]  pad_exp;
  } vec_t;

  // all pins enabled outputs in software mode; data starts at 0x00
  localparam vec_t VECS [8] = '{
    '{12'h3FC, 8'h00, 12'h3FC, 8'h00, 8'h00},
    '{12'h098, 8'hEB, 12'h3FC, 8'h22, 8'h22},
    '{12'h004, 8'hFF, 12'h0C4, 8'h21, 8'h23},
    '{12'h200, 8'h80, 12'h200, 8'h80, 8'hA3},
    '{12'h3FC, 8'h5A, 12'h000, 8'h00, 8'h5A},
    '{12'h000, 8'hFF, 12'h3FC, 8'h5A, 8'h5A},
    '{12'h154, 8'h0F, 12'h3FC, 8'h0F, 8'h0F},
    '{12'h2A8, 8'hF0, 12'h3FC, 8'hA5, 8'hA5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    #9;
    check("R1 pad_oe in reset", 32'(pad_oe), 32'h0);
    check("R1 pad_out in reset", 32'(pad_out), 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    bus_rd(12'h400, rd); check("R1 dir reset", rd, 32'h0);
    bus_rd(12'h420, rd); check("R1 alt reset", rd, 32'h0);
    bus_rd(12'h51C, rd); check("R1 den reset", rd, 32'h0);

    // R9 register map
    bus_wr(12'h400, 32'hFFFF_FF3C);
    bus_rd(12'h400, rd); check("R9 dir readback", rd, 32'h3C);
    bus_wr(12'h604, 32'h0000_00FF);
    bus_rd(12'h400, rd); check("R9 stray write leaves dir", rd, 32'h3C);
    bus_rd(12'h604, rd); check("R9 unmapped reads zero", rd, 32'h0);
    @(negedge clk);
    check("R4 rdata zero when idle", bus_rdata, 32'h0);

    // R10 write visible on the first edge
    bus_wr(12'h51C, 32'hFF);
    check("R10 oe after den write", 32'(pad_oe), 32'h3C);
    bus_wr(12'h400, 32'hFF);
    check("R5 oe follows dir", 32'(pad_oe), 32'hFF);

    // R2/R3 table
    foreach (VECS[i]) begin
      bus_wr(VECS[i].wr_addr, 32'(VECS[i].wr_data));
      check($sformatf("R2 pad after vec %0d", i), 32'(pad_out), 32'(VECS[i].pad_exp));
      bus_rd(VECS[i].rd_addr, rd);
      check($sformatf("R3 read vec %0d", i), rd, 32'(VECS[i].rd_exp));
    end

    // R8 synchronizer depth, inputs
    bus_wr(12'h400, 32'h00);
    check("R5 all inputs oe", 32'(pad_oe), 32'h0);
    @(negedge clk);
    pad_in = 8'h96;
    @(negedge clk);
    check("R8 one edge old", 32'(periph_in), 32'h00);
    @(negedge clk);
    check("R8 two edges new", 32'(periph_in), 32'h96);
    bus_rd(12'h3FC, rd); check("R3 input read", rd, 32'h96);
    bus_rd(12'h0C4, rd); check("R3 input masked", rd, 32'h10);

    // R3 mixed directions; data_q holds 0xA5
    bus_wr(12'h400, 32'h0F);
    bus_rd(12'h3FC, rd); check("R3 mixed dir read", rd, 32'h95);

    // R7 digital enable off on upper nibble
    bus_wr(12'h51C, 32'h0F);
    check("R7 periph_in gated", 32'(periph_in), 32'h06);
    check("R7 oe gated", 32'(pad_oe), 32'h0F);
    check("R7 out gated", 32'(pad_out), 32'h05);
    bus_wr(12'h400, 32'h00);
    bus_rd(12'h3FC, rd); check("R7 read gated", rd, 32'h06);

    // R6 peripheral mode
    bus_wr(12'h51C, 32'hFF);
    bus_wr(12'h400, 32'h0F);
    bus_wr(12'h3FC, 32'h33);
    periph_out = 8'hCC; periph_oe = 8'hAA;
    bus_wr(12'h420, 32'hF0);
    check("R6 out mixed", 32'(pad_out), 32'hC3);
    check("R6 oe mixed", 32'(pad_oe), 32'hAF);

    // R11 data write while peripheral owns upper nibble
    bus_wr(12'h3FC, 32'h5A);
    check("R11 pad keeps periph", 32'(pad_out), 32'hCA);
    bus_wr(12'h420, 32'h00);
    check("R11 data on return", 32'(pad_out), 32'h5A);
    check("R11 oe on return", 32'(pad_oe), 32'h0F);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule